// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port shared memory of `2**ADDR_W` words and watches what each port does to it. It keeps one interrupt flag for each port. The top word of the memory is the right port's mailbox and the word just below it is the left port's mailbox. When one port writes into the other port's mailbox, the owner's interrupt rises. When the owner reads its own mailbox, the interrupt falls. The content of the message is up to software. The storage array is outside this block.

Each port brings a chip enable, a write strobe, an output enable, a semaphore-select and a busy input from the contention arbiter. A busy port can neither raise the other side's flag nor clear its own. Semaphore-mode cycles never count as mailbox traffic. All decisions are sampled on the rising clock edge, and the flags are registers, so an effect shows on the outputs one cycle after the access.

Top module: `mailbox_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both `irq_l` and `irq_r` become 0 after that edge.
- R2: A left write (`l_en`=1, `l_we`=1, `l_sem`=0, `l_busy`=0) to address `2**ADDR_W-1` sets `irq_r` to 1 one cycle later.
- R3: A right write (`r_en`=1, `r_we`=1, `r_sem`=0, `r_busy`=0) to address `2**ADDR_W-2` sets `irq_l` to 1 one cycle later.
- R4: A right read (`r_en`=1, `r_we`=0, `r_oe`=1, `r_sem`=0, `r_busy`=0) of address `2**ADDR_W-1` clears `irq_r`, and the matching left read of address `2**ADDR_W-2` clears `irq_l`, one cycle later.
- R5: A port that reads the other port's mailbox clears no flag.
- R6: A write to the peer's mailbox while the writing port's busy input is 1 leaves the peer's flag unchanged.
- R7: A read of a port's own mailbox while that port's busy input is 1 leaves its flag unchanged.
- R8: An access with the port's semaphore-select at 1 changes no flag, whatever its address and direction.
- R9: An access with the port's chip enable at 0 changes no flag; a read with output enable at 0 does not clear a flag.
- R10: When a set and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R11: Accesses to any other address, and a port writing its own mailbox, leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable, active high |
| l_sem | input | 1 | Left semaphore-select, active high |
| l_busy | input | 1 | Left busy from the arbiter, active high |
| l_addr | input | ADDR_W | Left word address |
| r_en | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable, active high |
| r_sem | input | 1 | Right semaphore-select, active high |
| r_busy | input | 1 | Right busy from the arbiter, active high |
| r_addr | input | ADDR_W | Right word address |
| irq_l | output | 1 | Left interrupt flag, registered, active high |
| irq_r | output | 1 | Right interrupt flag, registered, active high |

## Verification
On every cycle the assertions check that a qualified set leaves the flag high, that an unopposed clear leaves it low, that set beats clear, that a flag with no event is stable, and that cycles in which both ports are deselected, busy or in semaphore mode move neither flag. What only the directed scenarios show is the address decode itself: that the right port's flag answers to the top word and the left's to the one below, that reading the peer's mailbox or writing one's own is inert, and that a read without output enable is ignored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic en;
    logic we;
    logic oe;
    logic sem;
    logic busy;
  } port_ctl_t;

  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;
  localparam int NUM_PORTS  = 2;

  // Mailbox owned by a port: right owns the top word, left the next one down.
  function automatic logic [31:0] mbox_word(input int aw, input bit owner_right);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return owner_right ? top : top - 32'd1;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              peer_set,
  output logic              own_clr
);
  localparam logic [31:0] OWN_W  = mbox_word(ADDR_W, IS_RIGHT);
  localparam logic [31:0] PEER_W = mbox_word(ADDR_W, !IS_RIGHT);
  localparam logic [ADDR_W-1:0] OWN_A  = OWN_W[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PEER_A = PEER_W[ADDR_W-1:0];

  logic mem_cycle, wr_cycle, rd_cycle;

  always_comb begin
    mem_cycle = ctl.en && !ctl.sem && !ctl.busy;
    wr_cycle  = mem_cycle && ctl.we;
    rd_cycle  = mem_cycle && !ctl.we && ctl.oe;
    peer_set  = wr_cycle && (addr == PEER_A);
    own_clr   = rd_cycle && (addr == OWN_A);
  end

  // R6 R7 R8: a busy or semaphore-mode port produces no mailbox event
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.busy || ctl.sem || !ctl.en) |-> !(peer_set || own_clr));

  // a single access cannot both set and clear
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(peer_set && own_clr));

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o);

  p_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> irq_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_o));

endmodule

// File: rtl/mailbox_irq_ctrl.sv
module mailbox_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_sem,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_sem,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              irq_l,
  output logic              irq_r
);
  port_ctl_t         ctl   [NUM_PORTS];
  logic [ADDR_W-1:0] addr  [NUM_PORTS];
  logic [NUM_PORTS-1:0] peer_set, own_clr, irq_q;

  always_comb begin
    ctl[PORT_LEFT]   = '{en: l_en, we: l_we, oe: l_oe, sem: l_sem, busy: l_busy};
    ctl[PORT_RIGHT]  = '{en: r_en, we: r_we, oe: r_oe, sem: r_sem, busy: r_busy};
    addr[PORT_LEFT]  = l_addr;
    addr[PORT_RIGHT] = r_addr;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int PEER = NUM_PORTS - 1 - p;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .IS_RIGHT (p == PORT_RIGHT)
    ) u_dec (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl[p]),
      .addr     (addr[p]),
      .peer_set (peer_set[p]),
      .own_clr  (own_clr[p])
    );

    // flag p is raised by the peer's write and dropped by port p's own read
    mbx_irq_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (peer_set[PEER]),
      .clr_i (own_clr[p]),
      .irq_o (irq_q[p])
    );
  end

  assign irq_l = irq_q[PORT_LEFT];
  assign irq_r = irq_q[PORT_RIGHT];

  // R8 R9: with both ports inert for mailbox purposes, neither flag moves
  p_inert_r9: assert property (@(posedge clk) disable iff (rst)
    ((l_sem || !l_en || l_busy) && (r_sem || !r_en || r_busy))
      |=> ($stable(irq_l) && $stable(irq_r)));

endmodule

// File: tb/sim_mailbox_irq_ctrl.sv
module sim_mailbox_irq_ctrl;
  localparam int AW = 4;
  localparam logic [AW-1:0] TOP = '1;         // right mailbox
  localparam logic [AW-1:0] LOW = TOP - 1'b1; // left mailbox

  logic clk = 0, rst = 1;
  logic l_en = 0, l_we = 0, l_oe = 0, l_sem = 0, l_busy = 0;
  logic r_en = 0, r_we = 0, r_oe = 0, r_sem = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic irq_l, irq_r;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mailbox_irq_ctrl #(.ADDR_W(AW)) u0 (.*);

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; l_oe = 0; l_sem = 0; l_busy = 0; l_addr = '0;
    r_en = 0; r_we = 0; r_oe = 0; r_sem = 0; r_busy = 0; r_addr = '0;
  endtask

  // drive current inputs through one edge, then release and settle
  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic lacc(logic we, logic oe, logic [AW-1:0] a);
    l_en = 1; l_we = we; l_oe = oe; l_addr = a;
  endtask

  task automatic racc(logic we, logic oe, logic [AW-1:0] a);
    r_en = 1; r_we = we; r_oe = oe; r_addr = a;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1; idle(); repeat (3) @(posedge clk); #1;
    check("R1 irq_l after reset", irq_l, 0);
    check("R1 irq_r after reset", irq_r, 0);
    rst = 0;
  endtask

  task automatic t_set_both();
    lacc(1, 0, TOP); tick();
    check("R2 left write top sets irq_r", irq_r, 1);
    check("R11 irq_l untouched", irq_l, 0);
    racc(1, 0, LOW); tick();
    check("R3 right write low sets irq_l", irq_l, 1);
  endtask

  task automatic t_peer_read();
    lacc(0, 1, TOP); tick();
    check("R5 left reads right mailbox", irq_r, 1);
    racc(0, 1, LOW); tick();
    check("R5 right reads left mailbox", irq_l, 1);
  endtask

  task automatic t_busy_clear();
    racc(0, 1, TOP); r_busy = 1; tick();
    check("R7 busy right read keeps irq_r", irq_r, 1);
    lacc(0, 1, LOW); l_busy = 1; tick();
    check("R7 busy left read keeps irq_l", irq_l, 1);
  endtask

  task automatic t_no_oe();
    racc(0, 0, TOP); tick();
    check("R9 read without oe keeps irq_r", irq_r, 1);
  endtask

  task automatic t_clear();
    racc(0, 1, TOP); tick();
    check("R4 right read top clears irq_r", irq_r, 0);
    lacc(0, 1, LOW); tick();
    check("R4 left read low clears irq_l", irq_l, 0);
  endtask

  task automatic t_busy_set();
    lacc(1, 0, TOP); l_busy = 1; tick();
    check("R6 busy left write no set", irq_r, 0);
    racc(1, 0, LOW); r_busy = 1; tick();
    check("R6 busy right write no set", irq_l, 0);
  endtask

  task automatic t_sem();
    lacc(1, 0, TOP); l_sem = 1; racc(1, 0, LOW); r_sem = 1; tick();
    check("R8 sem writes irq_r", irq_r, 0);
    check("R8 sem writes irq_l", irq_l, 0);
  endtask

  task automatic t_disabled();
    lacc(1, 0, TOP); l_en = 0; tick();
    check("R9 disabled left write", irq_r, 0);
  endtask

  task automatic t_other();
    lacc(1, 0, LOW); racc(1, 0, TOP); tick();
    check("R11 own mailbox write irq_l", irq_l, 0);
    check("R11 own mailbox write irq_r", irq_r, 0);
    lacc(1, 0, 4'd3); racc(1, 0, 4'd0); tick();
    check("R11 other address", irq_r | irq_l, 0);
  endtask

  task automatic t_set_wins();
    lacc(1, 0, TOP); racc(0, 1, TOP); tick();
    check("R10 set beats clear irq_r", irq_r, 1);
    racc(1, 0, LOW); lacc(0, 1, LOW); tick();
    check("R10 set beats clear irq_l", irq_l, 1);
    lacc(0, 1, LOW); tick();
    check("R4 irq_l clears after", irq_l, 0);
  endtask

  task automatic t_mid_reset();
    rst = 1; tick(); rst = 0;
    check("R1 irq_r cleared by reset", irq_r, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_set_both();
    t_peer_read();
    t_busy_clear();
    t_no_oe();
    t_clear();
    t_busy_set();
    t_sem();
    t_disabled();
    t_other();
    t_set_wins();
    t_mid_reset();
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule